// File: doc/BRIEF.md
# Round-Key Expander for a 128-bit ARX Block Cipher

This block turns a 128-bit master key into the 24 round keys, 192 bits each, that an add-rotate-xor block cipher consumes one per round. It works sequentially. A single-cycle `start` pulse captures the key. From the next cycle on, one round key leaves per clock, with a valid strobe and the round number beside it. A round data path can therefore take each key on the cycle it appears, and no key store is needed.

Internally the key is split into four 32-bit lanes, and each lane is rotated left by 8 bits when it is loaded. On every round, each lane adds a fixed constant modulo 2^32 and then rotates the sum by a fixed amount for that lane. The constant is picked by the round number and pre-rotated by the round number plus the lane number. The four updated lanes form the six-word round key, in which lane 1 appears three times. The updated lanes are also carried forward into the next round.

Top module: `lks_key_expander`

## Requirements
- R1: After reset, `rk_valid` is 0 and `rk_index` is 0, and both stay that way until `start` is seen.
- R2: On load, lane j (j = 0..3) is taken from `key[32*j+31 : 32*j]` and rotated left by 8 bits.
- R3: Round i uses the constant selected by i mod 4 from this set: 0 → 0xc3efe9db, 1 → 0x44626b02, 2 → 0x79e27c8a, 3 → 0x78df30ec.
- R4: In round i, lane j adds the selected constant rotated left by (i + j) mod 32 bits. The addition is modulo 2^32 and the carry is dropped.
- R5: Each sum is rotated left by a fixed amount for its lane: 1, 3, 6 and 11 bits for lanes 0, 1, 2 and 3. The rotated value is the lane's new value and is carried into round i+1.
- R6: Round-key layout, where L'j is the updated lane j: `rk[31:0]`=L'0, `rk[63:32]`=L'1, `rk[95:64]`=L'2, `rk[127:96]`=L'1, `rk[159:128]`=L'3, `rk[191:160]`=L'1.
- R7: When `start` is sampled high at a clock edge, round 0 is presented with `rk_valid`=1 after that edge. Rounds 1, 2, ... follow on consecutive cycles, and `rk_index` equals the round number.
- R8: Exactly 24 round keys (index 0 to 23) are produced. After index 23 is presented, `rk_valid` returns to 0 and stays there until the next `start`.
- R9: A `start` during a run abandons that run and restarts from round 0 with the newly presented key.
- R10: While idle (no `start`), changes on `key` have no effect and `rk_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle pulse that captures `key` and begins a run |
| key | input | 128 | Master key, sampled only in the cycle `start` is high |
| rk_valid | output | 1 | High while `rk` and `rk_index` carry a round key |
| rk_index | output | 5 | Round number of the key on `rk` (0 to 23) |
| rk | output | 192 | Current round key, six 32-bit words |

## Verification
Every result is due exactly one clock edge after its cause. Round 0 appears after the edge that samples `start`, round k after k further edges, and the drop of `rk_valid` after the edge that follows round 23. The bench drives inputs and samples outputs on the falling edge. A `start` driven at one falling edge is checked at the next one, and each further falling edge is checked against the next entry of a table of 24 keys that the bench computes in advance. Restart and idle stimuli use the same one-edge rule, so a result is never read in the cycle before it can appear.

// File: rtl/lks_pkg.sv
package lks_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_LANES = 4;
  localparam int RK_WORDS  = 6;
  localparam int ROUNDS    = 24;
  localparam int IDX_W     = $clog2(ROUNDS);
  localparam int ROT_W     = $clog2(WORD_W);
  localparam int KEY_W     = WORD_W * NUM_LANES;
  localparam int RK_W      = WORD_W * RK_WORDS;
  localparam int KEY_ROT   = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NUM_LANES-1:0][WORD_W-1:0] lane_vec_t;

  function automatic word_t rotl(input word_t x, input logic [ROT_W-1:0] s);
    logic [ROT_W-1:0] back;
    back = ROT_W'(WORD_W - int'(s));
    return (x << s) | (x >> back);
  endfunction

  function automatic word_t delta(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'hc3efe9db;
      2'd1:    return 32'h44626b02;
      2'd2:    return 32'h79e27c8a;
      default: return 32'h78df30ec;
    endcase
  endfunction

  function automatic logic [ROT_W-1:0] out_rot(input int lane);
    case (lane)
      0:       return ROT_W'(1);
      1:       return ROT_W'(3);
      2:       return ROT_W'(6);
      default: return ROT_W'(11);
    endcase
  endfunction

  // lane feeding each round-key word slot
  function automatic int slot_lane(input int slot);
    case (slot)
      0:       return 0;
      2:       return 2;
      4:       return 3;
      default: return 1;
    endcase
  endfunction

  function automatic word_t lane_step(input word_t w, input logic [IDX_W-1:0] idx,
                                      input int lane);
    logic [ROT_W-1:0] amt;
    amt = ROT_W'(idx) + ROT_W'(lane);
    return rotl(w + rotl(delta(idx[1:0]), amt), out_rot(lane));
  endfunction
endpackage

// File: rtl/lks_lane_unit.sv
module lks_lane_unit
  import lks_pkg::*;
#(
  parameter int LANE = 0
) (
  input  word_t            cur,
  input  logic [IDX_W-1:0] idx,
  output word_t            nxt
);
  assign nxt = lane_step(cur, idx, LANE);
endmodule

// File: rtl/lks_rk_pack.sv
module lks_rk_pack
  import lks_pkg::*;
(
  input  lane_vec_t        lanes,
  output logic [RK_W-1:0]  rk
);
  for (genvar s = 0; s < RK_WORDS; s++) begin : g_slot
    assign rk[s*WORD_W +: WORD_W] = lanes[slot_lane(s)];
  end
endmodule

// File: rtl/lks_seq.sv
module lks_seq
  import lks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             fire,
  output logic [IDX_W-1:0] round_idx,
  output logic             last_evt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

  logic             run_q;
  logic [IDX_W-1:0] nxt_q;

  assign fire      = start | run_q;
  assign round_idx = start ? '0 : nxt_q;
  assign last_evt  = fire && (round_idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      nxt_q <= '0;
    end else if (fire) begin
      run_q <= !last_evt;
      nxt_q <= round_idx + 1'b1;
    end else begin
      run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lks_key_expander.sv
module lks_key_expander
  import lks_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [KEY_W-1:0]         key,
  output logic                     rk_valid,
  output logic [IDX_W-1:0]         rk_index,
  output logic [RK_W-1:0]          rk
);
  logic             fire;
  logic             last_evt;
  logic [IDX_W-1:0] round_idx;
  lane_vec_t        state_q;
  lane_vec_t        src;
  lane_vec_t        nxt;
  logic [RK_W-1:0]  rk_d;

  lks_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .fire      (fire),
    .round_idx (round_idx),
    .last_evt  (last_evt)
  );

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    assign src[j] = start ? rotl(key[j*WORD_W +: WORD_W], ROT_W'(KEY_ROT)) : state_q[j];
    lks_lane_unit #(.LANE(j)) u_lane (
      .cur (src[j]),
      .idx (round_idx),
      .nxt (nxt[j])
    );
  end

  lks_rk_pack u_pack (
    .lanes (nxt),
    .rk    (rk_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= '0;
      rk       <= '0;
      rk_index <= '0;
      rk_valid <= 1'b0;
    end else if (fire) begin
      state_q  <= nxt;
      rk       <= rk_d;
      rk_index <= round_idx;
      rk_valid <= 1'b1;
    end else begin
      rk_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lks_key_expander_chk.sv
module lks_key_expander_chk
  import lks_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             rk_valid,
  input logic [IDX_W-1:0] rk_index,
  input logic [RK_W-1:0]  rk
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

  // R7
  start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rk_valid && rk_index == '0));

  // R7
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_valid && rk_index != LAST && !start) |=>
      (rk_valid && rk_index == $past(rk_index) + 1'b1));

  // R8
  run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_valid && rk_index == LAST && !start) |=> !rk_valid);

  // R8
  index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid |-> rk_index <= LAST);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rk_valid && !start) |=> !rk_valid);

  // R6
  repeat_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid |-> (rk[63:32] == rk[127:96] && rk[63:32] == rk[191:160]));
endmodule

bind lks_key_expander lks_key_expander_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .rk_valid (rk_valid),
  .rk_index (rk_index),
  .rk       (rk)
);

// File: tb/lks_key_expander_tb.sv
`timescale 1ns/1ps
module lks_key_expander_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] key = '0;
  logic         rk_valid;
  logic [4:0]   rk_index;
  logic [191:0] rk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [191:0] exp_tab [24];

  always #10 clk = ~clk;

  lks_key_expander u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key),
    .rk_valid(rk_valid), .rk_index(rk_index), .rk(rk)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    logic [63:0] t;
    t = {x, x} << (n % 32);
    return t[63:32];
  endfunction

  function automatic logic [31:0] cst(input int i);
    logic [31:0] c [4];
    c[0] = 32'hc3efe9db; c[1] = 32'h44626b02;
    c[2] = 32'h79e27c8a; c[3] = 32'h78df30ec;
    return c[i % 4];
  endfunction

  task automatic build_table(input logic [127:0] k);
    logic [31:0] w [4];
    int sh [4];
    sh[0] = 1; sh[1] = 3; sh[2] = 6; sh[3] = 11;
    for (int j = 0; j < 4; j++) w[j] = rl(k[32*j +: 32], 8);
    for (int i = 0; i < 24; i++) begin
      for (int j = 0; j < 4; j++) w[j] = rl(w[j] + rl(cst(i), i + j), sh[j]);
      exp_tab[i] = {w[1], w[3], w[1], w[2], w[1], w[0]};
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expects to be called at a falling edge; leaves at a falling edge
  task automatic run_key(input logic [127:0] k, input int nrounds, input string req);
    build_table(k);
    start = 1'b1;
    key   = k;
    @(negedge clk);
    start = 1'b0;
    for (int r = 0; r < nrounds; r++) begin
      chk(rk_valid == 1'b1, "R7", "rk_valid", 192'(rk_valid), 192'd1);
      chk(rk_index == 5'(r), "R7", "rk_index", 192'(rk_index), 192'(r));
      chk(rk == exp_tab[r], req, "rk", rk, exp_tab[r]);
      @(negedge clk);
    end
  endtask

  initial begin
    logic [127:0] k1;
    void'($urandom(32'h1EA5));
    repeat (3) @(negedge clk);
    // R1
    chk(rk_valid == 1'b0, "R1", "rk_valid in reset", 192'(rk_valid), 192'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rk_valid == 1'b0, "R1", "rk_valid after reset", 192'(rk_valid), 192'd0);
    chk(rk_index == 5'd0, "R1", "rk_index after reset", 192'(rk_index), 192'd0);

    // directed corner keys: zero lanes (R3/R4 alone), all ones (carry wrap R4)
    run_key('0, 24, "R3");
    chk(rk_valid == 1'b0, "R8", "rk_valid after round 23", 192'(rk_valid), 192'd0);
    run_key({128{1'b1}}, 24, "R4");
    chk(rk_valid == 1'b0, "R8", "rk_valid after round 23", 192'(rk_valid), 192'd0);
    // lane placement and rotations (R2, R5, R6)
    run_key(128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0, 24, "R2");
    @(negedge clk);
    chk(rk_valid == 1'b0, "R8", "rk_valid stays low", 192'(rk_valid), 192'd0);

    // constrained random keys
    for (int n = 0; n < 6; n++) begin
      k1 = {$urandom, $urandom, $urandom, $urandom};
      run_key(k1, 24, (n % 2 == 0) ? "R5" : "R6");
      chk(rk_valid == 1'b0, "R8", "rk_valid after run", 192'(rk_valid), 192'd0);
    end

    // R9: restart mid-run, then restart on the last round
    run_key({$urandom, $urandom, $urandom, $urandom}, 6, "R9");
    run_key({$urandom, $urandom, $urandom, $urandom}, 23, "R9");
    run_key({$urandom, $urandom, $urandom, $urandom}, 24, "R9");
    chk(rk_valid == 1'b0, "R8", "rk_valid after restart run", 192'(rk_valid), 192'd0);

    // R10: key wiggles while idle
    for (int n = 0; n < 8; n++) begin
      key = {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
      chk(rk_valid == 1'b0, "R10", "rk_valid idle", 192'(rk_valid), 192'd0);
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule